// File: doc/BRIEF.md
# Chunked Masking Random Generator with Block-Rate Reseed

This block supplies a 160-bit word of fresh pseudo-random bits to a masked block-cipher datapath each time the datapath asks for one. The word feeds twenty S-boxes with one 8-bit lane each. The sixteen data-path S-boxes take the low 128 bits, and the four key-expansion S-boxes take the top 32 bits. In every data lane, the byte serves as that S-box's output mask and also as the input mask for the matching state byte.

The state is made of five independent 32-bit Galois LFSR chunks. Each 32-bit segment of the output is filled from one chunk. The chunk that feeds a segment swaps on every update, so masks used as S-box inputs in one round never come from the same chunk as the S-box output masks of the next round.

A block counter counts finished cipher blocks. When the count reaches the programmed rate, the block fetches five 32-bit entropy words over a request/acknowledge pair, one word per chunk. While it does this it reports busy and ignores update strobes.

Top module: `masking_prng`

## Requirements
- R1: While reset (active low, sampled on the clock) is applied and in the cycle after, `prd_o` is all zeros and both `busy_o` and `ent_req_o` are low. Every chunk then holds its default seed. The default seed of chunk i is 32'h13579BDF + i * 32'h2468ACE0.
- R2: An accepted update is a strobe on `upd_i` while `busy_o` is low. Each accepted update advances every chunk by one Galois step. The step shifts the state right by one and, if the bit shifted out was 1, XORs in 32'h80200003. The new output appears in the cycle after the strobe.
- R3: Output segment s is `prd_o[32*s+31 : 32*s]`, for s from 0 to 4, and segment 4 is the key-expansion part. With lane phase p = 0, segment s carries chunk s. With p = 1, it carries chunk (s+1) mod 5. An accepted update forms its output with the current p and then inverts p. p is 0 after reset.
- R4: `prd_o` keeps its value in every cycle that has no accepted update and does not end a reseed.
- R5: `rate_i` selects the reseed interval. 3'b001 reseeds after every finished block, 3'b010 after every 64 blocks, and 3'b100 after every 8192 blocks; any other code behaves as 3'b100. A `blk_done_i` pulse that completes the interval raises `busy_o` and `ent_req_o` in the next cycle and clears the count.
- R6: While `ent_req_o` is high, each cycle with `ent_ack_i` high loads `ent_data_i` into the next chunk, in order from chunk 0 to chunk 4. An acknowledge while `ent_req_o` is low has no effect.
- R7: An entropy word of all zeros loads the chunk's default seed instead of zero.
- R8: `busy_o` is high from the cycle after the triggering block until the cycle after the fifth acknowledge. While it is high, `upd_i` and `blk_done_i` are ignored, and `ent_req_o` is never high without `busy_o`.
- R9: In the cycle after the fifth acknowledge, `prd_o` takes the reloaded chunks arranged with the unchanged phase p, and `busy_o` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Request a fresh random word |
| blk_done_i | input | 1 | One cipher block has finished |
| rate_i | input | 3 | One-hot reseed interval select |
| ent_req_o | output | 1 | Entropy word wanted |
| ent_ack_i | input | 1 | Entropy word valid this cycle |
| ent_data_i | input | 32 | Entropy word |
| busy_o | output | 1 | Reseed in progress |
| prd_o | output | 160 | Pseudo-random word for the S-boxes |

## Verification
The assertions assume that `ent_ack_i` arrives as single-cycle pulses and that the inputs change only between clock edges. They also assume that `upd_i` and `blk_done_i` raised during a reseed carry no meaning. The bench drives every input on the falling edge. It deliberately raises update, block and acknowledge strobes at the wrong moments: acknowledges while idle, and updates and blocks while busy. These stimuli stay inside the assumptions while still showing that the strobes are ignored. A cycle-level model in the bench is built from the requirements alone. It predicts the word, busy and request after every edge, across all three rate codes and one invalid code.

// File: rtl/mprng_pkg.sv
// Shared sizes, types and arithmetic for the chunked masking generator.
// Assumes the output width equals the chunk count times the chunk width.
package mprng_pkg;
    parameter int unsigned CHUNK_W    = 32;
    parameter int unsigned NUM_CHUNKS = 5;
    parameter int unsigned LANE_W     = 8;
    parameter int unsigned DATA_LANES = 16;
    parameter int unsigned KEY_LANES  = 4;
    parameter int unsigned PRD_W      = LANE_W * (DATA_LANES + KEY_LANES);
    parameter int unsigned IDX_W      = $clog2(NUM_CHUNKS);

    parameter logic [CHUNK_W-1:0] LFSR_TAPS  = 32'h80200003;
    parameter logic [CHUNK_W-1:0] SEED_BASE  = 32'h13579BDF;
    parameter logic [CHUNK_W-1:0] SEED_DELTA = 32'h2468ACE0;

    parameter int unsigned THR_FAST = 1;
    parameter int unsigned THR_MID  = 64;
    parameter int unsigned THR_SLOW = 8192;
    parameter int unsigned CTR_W    = $clog2(THR_SLOW);

    parameter logic [2:0] RATE_FAST = 3'b001;
    parameter logic [2:0] RATE_MID  = 3'b010;
    parameter logic [2:0] RATE_SLOW = 3'b100;

    typedef logic [NUM_CHUNKS-1:0][CHUNK_W-1:0] chunk_vec_t;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_FETCH   = 2'd1,
        RS_PUBLISH = 2'd2
    } rs_state_e;

    // One Galois step: shift right, fold the taps in when a one drops out.
    function automatic logic [CHUNK_W-1:0] lfsr_next(logic [CHUNK_W-1:0] s);
        logic [CHUNK_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_TAPS;
        return n;
    endfunction

    // Fixed nonzero seed of chunk idx.
    function automatic logic [CHUNK_W-1:0] default_seed(int unsigned idx);
        return SEED_BASE + CHUNK_W'(idx) * SEED_DELTA;
    endfunction
endpackage

// File: rtl/mprng_chunk.sv
// One LFSR chunk of the generator. It steps on step_i and loads seed_i on
// load_i, replacing an all-zero seed with its own default. It assumes the two
// strobes never come together; load wins if they do.
module mprng_chunk #(
    parameter int unsigned IDX = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step_i,
    input  logic                            load_i,
    input  logic [mprng_pkg::CHUNK_W-1:0]   seed_i,
    output logic [mprng_pkg::CHUNK_W-1:0]   state_o,
    output logic [mprng_pkg::CHUNK_W-1:0]   next_o
);
    import mprng_pkg::*;

    localparam logic [CHUNK_W-1:0] DFLT = default_seed(IDX);

    logic [CHUNK_W-1:0] state_q;

    // Next-step value, used by the lane map before the register takes it.
    always_comb next_o = lfsr_next(state_q);

    // Chunk state register: default at reset, reload, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DFLT;
        end else if (load_i) begin
            state_q <= (seed_i == '0) ? DFLT : seed_i;
        end else if (step_i) begin
            state_q <= next_o;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/mprng_reseed_ctrl.sv
// Counts finished blocks against the selected interval and runs the entropy
// fetch: one chunk per acknowledge, then one cycle to publish the new word.
// Assumes acknowledges are single-cycle pulses.
module mprng_reseed_ctrl (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              blk_done_i,
    input  logic [2:0]                        rate_i,
    input  logic                              ent_ack_i,
    output logic                              busy_o,
    output logic                              req_o,
    output logic                              publish_o,
    output logic [mprng_pkg::NUM_CHUNKS-1:0]  load_o,
    output logic [mprng_pkg::IDX_W-1:0]       fetch_idx_o
);
    import mprng_pkg::*;

    localparam logic [CTR_W-1:0] LIM_FAST = CTR_W'(THR_FAST - 1);
    localparam logic [CTR_W-1:0] LIM_MID  = CTR_W'(THR_MID - 1);
    localparam logic [CTR_W-1:0] LIM_SLOW = CTR_W'(THR_SLOW - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);

    rs_state_e          state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [CTR_W-1:0]   cnt_q;
    logic [CTR_W-1:0]   limit;

    // Decode the rate code into the last count before a reseed.
    always_comb begin
        case (rate_i)
            RATE_FAST: limit = LIM_FAST;
            RATE_MID:  limit = LIM_MID;
            default:   limit = LIM_SLOW;
        endcase
    end

    // Block counter and fetch sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                RS_IDLE: begin
                    if (blk_done_i) begin
                        if (cnt_q >= limit) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= RS_FETCH;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RS_FETCH: begin
                    if (ent_ack_i) begin
                        if (idx_q == LAST_IDX) begin
                            state_q <= RS_PUBLISH;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                RS_PUBLISH: state_q <= RS_IDLE;
                default:    state_q <= RS_IDLE;
            endcase
        end
    end

    // Per-chunk load strobes, one per acknowledged word.
    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_load
        assign load_o[i] = (state_q == RS_FETCH) && ent_ack_i && (idx_q == IDX_W'(i));
    end

    assign busy_o      = (state_q != RS_IDLE);
    assign req_o       = (state_q == RS_FETCH);
    assign publish_o   = (state_q == RS_PUBLISH);
    assign fetch_idx_o = idx_q;
endmodule

// File: rtl/mprng_lane_map.sv
// Places the chunks into the output segments. Phase 0 maps segment s to
// chunk s. Phase 1 maps it to chunk (s+1) mod N, so each segment changes
// source from one word to the next. Purely combinational.
module mprng_lane_map (
    input  mprng_pkg::chunk_vec_t              chunks_i,
    input  logic                               phase_i,
    output logic [mprng_pkg::PRD_W-1:0]        prd_o
);
    import mprng_pkg::*;

    for (genvar s = 0; s < NUM_CHUNKS; s++) begin : g_seg
        localparam int unsigned ALT = (s + 1) % NUM_CHUNKS;
        assign prd_o[s*CHUNK_W +: CHUNK_W] = phase_i ? chunks_i[ALT] : chunks_i[s];
    end
endmodule

// File: rtl/masking_prng.sv
// Top of the chunked masking generator. It registers one 160-bit word per
// accepted update and republishes the word after every reseed. It assumes
// upd_i and blk_done_i are cycle strobes from the cipher control.
module masking_prng (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              upd_i,
    input  logic                              blk_done_i,
    input  logic [2:0]                        rate_i,
    output logic                              ent_req_o,
    input  logic                              ent_ack_i,
    input  logic [mprng_pkg::CHUNK_W-1:0]     ent_data_i,
    output logic                              busy_o,
    output logic [mprng_pkg::PRD_W-1:0]       prd_o
);
    import mprng_pkg::*;

    logic                   busy;
    logic                   publish;
    logic [NUM_CHUNKS-1:0]  load;
    logic [IDX_W-1:0]       fetch_idx;
    logic                   accept;
    logic                   phase_q;
    chunk_vec_t             cur;
    chunk_vec_t             nxt;
    chunk_vec_t             map_in;
    logic [PRD_W-1:0]       mapped;
    logic [PRD_W-1:0]       prd_q;

    mprng_reseed_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_done_i  (blk_done_i),
        .rate_i      (rate_i),
        .ent_ack_i   (ent_ack_i),
        .busy_o      (busy),
        .req_o       (ent_req_o),
        .publish_o   (publish),
        .load_o      (load),
        .fetch_idx_o (fetch_idx)
    );

    // An update counts only outside a reseed.
    assign accept = upd_i && !busy;

    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
        mprng_chunk #(.IDX(i)) u_chunk (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (accept),
            .load_i  (load[i]),
            .seed_i  (ent_data_i),
            .state_o (cur[i]),
            .next_o  (nxt[i])
        );
    end

    // Publishing uses the reloaded state; an update uses the stepped state.
    assign map_in = publish ? cur : nxt;

    mprng_lane_map u_map (
        .chunks_i (map_in),
        .phase_i  (phase_q),
        .prd_o    (mapped)
    );

    // Output word register and lane phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q   <= '0;
            phase_q <= 1'b0;
        end else if (accept) begin
            prd_q   <= mapped;
            phase_q <= ~phase_q;
        end else if (publish) begin
            prd_q   <= mapped;
        end
    end

    assign prd_o  = prd_q;
    assign busy_o = busy;
endmodule

// File: rtl/masking_prng_checker.sv
// Temporal checks on the generator's ports and lane phase, bound to the top.
module masking_prng_checker (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              upd_i,
    input logic                              blk_done_i,
    input logic [2:0]                        rate_i,
    input logic                              ent_req_o,
    input logic                              ent_ack_i,
    input logic                              busy_o,
    input logic [mprng_pkg::PRD_W-1:0]       prd_o,
    input logic                              phase_q,
    input logic [mprng_pkg::IDX_W-1:0]       fetch_idx
);
    import mprng_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);

    assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req_o |-> busy_o);

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd_i && !busy_o) && !(busy_o && !ent_req_o)) |=> $stable(prd_o));

    assert_phase_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !busy_o) |=> (phase_q != $past(phase_q)));

    assert_phase_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(phase_q));

    assert_publish_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ent_req_o) |=> !busy_o);

    assert_fetch_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_req_o && ent_ack_i && fetch_idx != LAST_IDX)
            |=> (ent_req_o && fetch_idx == IDX_W'($past(fetch_idx) + 1'b1)));

    assert_fast_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == RATE_FAST && blk_done_i && !busy_o) |=> ent_req_o);
endmodule

bind masking_prng masking_prng_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_i      (upd_i),
    .blk_done_i (blk_done_i),
    .rate_i     (rate_i),
    .ent_req_o  (ent_req_o),
    .ent_ack_i  (ent_ack_i),
    .busy_o     (busy_o),
    .prd_o      (prd_o),
    .phase_q    (phase_q),
    .fetch_idx  (fetch_idx)
);

// File: tb/masking_prng_bench.sv
`timescale 1ns/1ps
// Bench: a cycle model written from the requirements predicts every output.
module masking_prng_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd = 1'b0;
    logic         blk = 1'b0;
    logic [2:0]   rate = 3'b001;
    logic         ack = 1'b0;
    logic [31:0]  ent = '0;
    logic         req;
    logic         busy;
    logic [159:0] prd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    masking_prng u_masking_prng (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .blk_done_i(blk), .rate_i(rate),
        .ent_req_o(req), .ent_ack_i(ack), .ent_data_i(ent), .busy_o(busy), .prd_o(prd)
    );

    always #4 clk = ~clk;

    // Reference model state
    logic [31:0]  m_ch [5];
    logic         m_ph;
    int           m_cnt;
    int           m_st;    // 0 idle, 1 fetching, 2 publishing
    int           m_idx;
    logic [159:0] m_prd;

    function automatic logic [31:0] seed_of(int i);
        return 32'h13579BDF + 32'(i) * 32'h2468ACE0;
    endfunction

    function automatic logic [31:0] step_of(logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
    endfunction

    function automatic int interval(logic [2:0] r);
        if (r == 3'b001) return 1;
        if (r == 3'b010) return 64;
        return 8192;
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        logic [31:0] t [5];
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) m_ch[i] = seed_of(i);
            m_ph = 1'b0; m_cnt = 0; m_st = 0; m_idx = 0; m_prd = '0;
        end else if (m_st == 0) begin
            if (upd) begin
                for (int i = 0; i < 5; i++) t[i] = step_of(m_ch[i]);
                for (int s = 0; s < 5; s++) m_prd[32*s +: 32] = m_ph ? t[(s+1)%5] : t[s];
                for (int i = 0; i < 5; i++) m_ch[i] = t[i];
                m_ph = ~m_ph;
            end
            if (blk) begin
                if (m_cnt + 1 >= interval(rate)) begin
                    m_cnt = 0; m_st = 1; m_idx = 0;
                end else m_cnt = m_cnt + 1;
            end
        end else if (m_st == 1) begin
            if (ack) begin
                m_ch[m_idx] = (ent == 0) ? seed_of(m_idx) : ent;
                if (m_idx == 4) m_st = 2; else m_idx = m_idx + 1;
            end
        end else begin
            for (int s = 0; s < 5; s++) m_prd[32*s +: 32] = m_ph ? m_ch[(s+1)%5] : m_ch[s];
            m_st = 0;
        end
    end

    task automatic check1(input bit ok, input string tag, input logic [159:0] act,
                          input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check1(prd === m_prd, {tag, " word"}, prd, m_prd);
        check1(busy === (m_st != 0), {tag, " busy"}, 160'(busy), 160'(m_st != 0));
        check1(req === (m_st == 1), {tag, " req"}, 160'(req), 160'(m_st == 1));
    endtask

    // One cycle: drive at the falling edge, compare at the next falling edge.
    task automatic cyc(input logic u, input logic b, input logic a, input logic [31:0] d,
                       input string tag);
        upd = u; blk = b; ack = a; ent = d;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic reseed(input logic [31:0] base, input int zero_at);
        for (int k = 0; k < 5; k++) begin
            cyc(1'b1, 1'b1, 1'b0, 32'h0, "R8 strobes ignored");
            check1(req === 1'b1, "R6 request held", 160'(req), 160'd1);
            cyc(1'b0, 1'b0, 1'b1, (k == zero_at) ? 32'h0 : base + 32'(k) * 32'h01010101,
                "R6 R7 load");
        end
        cyc(1'b0, 1'b0, 1'b0, 32'h0, "R9 publish");
        check1(busy === 1'b0, "R9 busy falls", 160'(busy), 160'd0);
    endtask

    task automatic run_blocks(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(k % 3 == 0, 1'b1, 1'b0, 32'h0, tag);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check1(prd === '0, "R1 word", prd, '0);
        check1(busy === 1'b0 && req === 1'b0, "R1 flags", 160'({busy, req}), 160'd0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 32'h0, "R1 idle");
        cyc(1'b0, 1'b0, 1'b0, 32'h0, "R4 idle");
        for (int k = 0; k < 24; k++) begin
            cyc(1'b1, 1'b0, 1'b0, 32'h0, "R2 R3 update");
            if (k % 4 == 1) cyc(1'b0, 1'b0, 1'b0, 32'h0, "R4 hold");
        end
        cyc(1'b0, 1'b0, 1'b1, 32'hCAFEF00D, "R6 stray ack");
        cyc(1'b1, 1'b0, 1'b0, 32'h0, "R6 stray ack no load");
        // every-block rate
        rate = 3'b001;
        cyc(1'b0, 1'b1, 1'b0, 32'h0, "R5 fast trigger");
        check1(busy === 1'b1, "R5 fast busy", 160'(busy), 160'd1);
        reseed(32'h3C3C0001, 2);
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, 32'h0, "R3 R9 after reseed");
        cyc(1'b0, 1'b1, 1'b0, 32'h0, "R5 fast again");
        reseed(32'h00000000, 9);
        cyc(1'b1, 1'b0, 1'b0, 32'h0, "R7 all zero entropy");
        // 64-block rate
        rate = 3'b010;
        run_blocks(63, "R5 mid count");
        check1(busy === 1'b0, "R5 mid not yet", 160'(busy), 160'd0);
        cyc(1'b0, 1'b1, 1'b0, 32'h0, "R5 mid trigger");
        check1(busy === 1'b1, "R5 mid busy", 160'(busy), 160'd1);
        reseed(32'h5A5A1234, 7);
        run_blocks(63, "R5 R8 count after busy blocks");
        check1(busy === 1'b0, "R8 busy blocks not counted", 160'(busy), 160'd0);
        cyc(1'b1, 1'b1, 1'b0, 32'h0, "R5 mid trigger 2");
        reseed(32'h87654321, 4);
        // 8192-block rate, then an invalid code
        rate = 3'b100;
        run_blocks(8191, "R5 slow count");
        check1(busy === 1'b0, "R5 slow not yet", 160'(busy), 160'd0);
        cyc(1'b0, 1'b1, 1'b0, 32'h0, "R5 slow trigger");
        check1(busy === 1'b1, "R5 slow busy", 160'(busy), 160'd1);
        reseed(32'h0F0F0F0F, 0);
        rate = 3'b011;
        run_blocks(8191, "R5 invalid count");
        check1(busy === 1'b0, "R5 invalid not yet", 160'(busy), 160'd0);
        cyc(1'b0, 1'b1, 1'b0, 32'h0, "R5 invalid trigger");
        check1(busy === 1'b1, "R5 invalid busy", 160'(busy), 160'd1);
        reseed(32'hA1B2C3D4, 3);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 1'b0, 32'h0, "R2 R3 final updates");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule